// File: doc/BRIEF.md
# Framed Serial Codec Data Port

This block is the digital side of a voice codec's serial link. One bit clock runs the whole port. The transmit and receive directions each have their own frame-sync input, so the two directions are timed separately. Every frame carries one 16-bit word in each direction, most significant bit first. The first 13 bits are a signed audio sample. The last three bits are a volume code on the inbound side and zero padding on the outbound side. In normal use the frame syncs pulse once every 256 bit clocks, which gives 8 kHz frames from a 2.048 MHz clock.

On the transmit side, the port captures the parallel sample at the frame-sync rising edge. It then drives the word on its serial output, one bit per rising clock edge. A microphone mute input forces the captured word to zero. On the receive side, the port samples the serial input on falling clock edges. When all 16 bits have arrived, it presents the sample and the volume code in parallel together with a one-cycle strobe. An active-low power-down input releases the output pad and makes the port ignore frame syncs.

Neither direction can apply back-pressure, because the frame syncs fix the line timing. `tx_sample` and `mic_mute` are read once per frame, at the capture edge. `rx_valid` is a valid-only strobe with no ready. The consumer must take `rx_sample` and `rx_vol` while `rx_valid` is high or afterwards. Those outputs hold until the next complete word arrives. The serial output is split into a data bit `dout` and an enable `dout_en`, and a pad cell outside this block turns them into a real high-impedance pin. Reset is asynchronous and active low.

Top module: `codec_serial_port`

## Requirements
- R1: While and right after reset, `dout_en`, `dout`, `rx_valid`, `rx_sample` and `rx_vol` are all 0.
- R2: A rising clock edge that sees `fsx` high, where the previous edge saw it low, starts a transmit word. `dout` shows `{tx_sample, 3'b000}` MSB first, bit 15 in the cycle after that edge, and the next bit after each following rising edge.
- R3: `dout_en` is high for exactly 16 clock cycles per transmit word, ending after the last pad bit. Outside that window `dout_en` and `dout` are 0.
- R4: `tx_sample` is captured only at the frame-start edge. Changing it during the word leaves the bits already on the line, and those still to come, unaffected.
- R5: If `mic_mute` is high at the frame-start edge, all 16 transmitted bits are 0. A change of `mic_mute` during the word has no effect on that word.
- R6: A new `fsx` rising edge during a word restarts the transmit word from bit 15, with the newly captured sample.
- R7: Receive bits are sampled on falling clock edges. The first falling edge that sees `fsr` high, after one that saw it low, takes bit 15 from `din`. The next 15 falling edges take bits 14 down to 0.
- R8: At the falling edge that takes bit 0, `rx_sample` becomes bits 15..3 and `rx_vol` becomes bits 2..0, and `rx_valid` goes high for one clock period. Both outputs hold until the next complete word.
- R9: A new `fsr` rising edge during a receive word discards the partial word and starts again at bit 15.
- R10: While `pwr_n` is low, `dout_en` is 0 and any word in progress in either direction is abandoned. Frame syncs are ignored, `rx_valid` stays 0, and `rx_sample` and `rx_vol` keep their values.
- R11: A frame sync held high for several cycles starts only one word. Only its rising edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; transmit on rising, receive on falling edges |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_n | input | 1 | Power-down, active low; high for normal operation |
| fsx | input | 1 | Transmit frame sync |
| tx_sample | input | 13 | Audio sample to transmit, read at frame start |
| mic_mute | input | 1 | Forces the transmitted word to zero when high at frame start |
| dout | output | 1 | Serial transmit data bit |
| dout_en | output | 1 | Pad drive enable for `dout`; low means high impedance |
| fsr | input | 1 | Receive frame sync |
| din | input | 1 | Serial receive data |
| rx_sample | output | 13 | Last received audio sample |
| rx_vol | output | 3 | Last received volume code; 0 is loudest, 7 is most attenuated |
| rx_valid | output | 1 | One-cycle strobe when a word has been received |

## Verification
The bench builds the port with its default widths: a 13-bit sample and a 3-bit tail, giving a 16-bit word and a 4-bit bit counter. With these values, the counter's last state (15) and the boundary between sample bits and tail bits (bit 13) are exercised in every frame. Frames run at the full 256-clock length with varied sample and volume patterns. Short frames interrupted by a fresh sync test the restart paths. Syncs held high test edge-only detection. Power-down is dropped both mid-word and across a sync.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;

  localparam int unsigned CP_SAMPLE_W = 13;
  localparam int unsigned CP_TAIL_W   = 3;

  function automatic int unsigned cp_cnt_w(input int unsigned w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction

endpackage

// File: rtl/cport_tx_shifter.sv
module cport_tx_shifter
  import codec_port_pkg::*;
#(
  parameter int unsigned SAMPLE_W = CP_SAMPLE_W,
  parameter int unsigned TAIL_W   = CP_TAIL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_n,
  input  logic                fsync,
  input  logic                mute,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                ser_bit,
  output logic                ser_act
);

  localparam int unsigned WORD_W = SAMPLE_W + TAIL_W;
  localparam int unsigned CNT_W  = cp_cnt_w(WORD_W);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] TAIL_POS = CNT_W'(SAMPLE_W);

  logic              fs_q;
  logic              active;
  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              start;

  assign start = pwr_n && fsync && !fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      active <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
    end else begin
      fs_q <= fsync;
      if (!pwr_n) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (start) begin
        sh     <= mute ? '0 : {sample, {TAIL_W{1'b0}}};
        cnt    <= '0;
        active <= 1'b1;
      end else if (active) begin
        sh  <= {sh[WORD_W-2:0], 1'b0};
        cnt <= cnt + 1'b1;
        if (cnt == LAST) active <= 1'b0;
      end
    end
  end

  assign ser_bit = sh[WORD_W-1];
  assign ser_act = active;

  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt >= TAIL_POS) |-> !sh[WORD_W-1]);

  assert_word_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == LAST && !start) |=> !active);

  assert_mute_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mute) |=> (sh == '0));

  assert_pdn_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> !active);

endmodule

// File: rtl/cport_rx_capture.sv
module cport_rx_capture
  import codec_port_pkg::*;
#(
  parameter int unsigned SAMPLE_W = CP_SAMPLE_W,
  parameter int unsigned TAIL_W   = CP_TAIL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_n,
  input  logic                fsync,
  input  logic                ser_in,
  output logic [SAMPLE_W-1:0] sample,
  output logic [TAIL_W-1:0]   tail,
  output logic                strobe
);

  localparam int unsigned WORD_W = SAMPLE_W + TAIL_W;
  localparam int unsigned CNT_W  = cp_cnt_w(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              fs_q;
  logic              busy;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] sh_next;
  logic [CNT_W-1:0]  cnt;
  logic              start;

  assign start   = pwr_n && fsync && !fs_q;
  assign sh_next = {sh[WORD_W-2:0], ser_in};

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      busy   <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
      sample <= '0;
      tail   <= '0;
      strobe <= 1'b0;
    end else begin
      fs_q <= fsync;
      if (!pwr_n) begin
        busy   <= 1'b0;
        strobe <= 1'b0;
      end else if (start) begin
        sh     <= sh_next;
        cnt    <= CNT_W'(1);
        busy   <= 1'b1;
        strobe <= 1'b0;
      end else if (busy) begin
        sh  <= sh_next;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy   <= 1'b0;
          strobe <= 1'b1;
          sample <= sh_next[WORD_W-1 -: SAMPLE_W];
          tail   <= sh_next[TAIL_W-1:0];
        end else begin
          strobe <= 1'b0;
        end
      end else begin
        strobe <= 1'b0;
      end
    end
  end

  assert_strobe_single_R8: assert property (@(negedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  assert_strobe_holds_R8: assert property (@(negedge clk) disable iff (!rst_n)
    !strobe |-> $stable(sample) && $stable(tail));

  assert_pdn_quiet_R10: assert property (@(negedge clk) disable iff (!rst_n)
    !pwr_n |=> !strobe);

endmodule

// File: rtl/cport_out_gate.sv
module cport_out_gate (
  input  logic pwr_n,
  input  logic bit_in,
  input  logic act_in,
  output logic pad_bit,
  output logic pad_en
);

  assign pad_en  = act_in && pwr_n;
  assign pad_bit = pad_en && bit_in;

endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
  import codec_port_pkg::*;
#(
  parameter int unsigned SAMPLE_W = CP_SAMPLE_W,
  parameter int unsigned TAIL_W   = CP_TAIL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_n,
  input  logic                fsx,
  input  logic [SAMPLE_W-1:0] tx_sample,
  input  logic                mic_mute,
  output logic                dout,
  output logic                dout_en,
  input  logic                fsr,
  input  logic                din,
  output logic [SAMPLE_W-1:0] rx_sample,
  output logic [TAIL_W-1:0]   rx_vol,
  output logic                rx_valid
);

  logic tx_bit;
  logic tx_act;

  cport_tx_shifter #(.SAMPLE_W(SAMPLE_W), .TAIL_W(TAIL_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_n   (pwr_n),
    .fsync   (fsx),
    .mute    (mic_mute),
    .sample  (tx_sample),
    .ser_bit (tx_bit),
    .ser_act (tx_act)
  );

  cport_out_gate u_gate (
    .pwr_n   (pwr_n),
    .bit_in  (tx_bit),
    .act_in  (tx_act),
    .pad_bit (dout),
    .pad_en  (dout_en)
  );

  cport_rx_capture #(.SAMPLE_W(SAMPLE_W), .TAIL_W(TAIL_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_n  (pwr_n),
    .fsync  (fsr),
    .ser_in (din),
    .sample (rx_sample),
    .tail   (rx_vol),
    .strobe (rx_valid)
  );

  assert_quiet_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> !dout);

endmodule

// File: tb/codec_serial_port_test.sv
module codec_serial_port_test;

  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_n = 1'b1;
  logic        fsx = 1'b0;
  logic        fsr = 1'b0;
  logic        din = 1'b0;
  logic        mic_mute = 1'b0;
  logic [12:0] tx_sample = '0;
  logic        dout, dout_en, rx_valid;
  logic [12:0] rx_sample;
  logic [2:0]  rx_vol;

  int    vectors = 0;
  int    errors = 0;
  bit    finished = 0;
  string cur_req = "R1";

  int m_tidx = -1, m_tword = 0, m_fsx_prev = 0;
  int m_ridx = -1, m_rword = 0, m_fsr_prev = 0;
  int m_valid = 0, m_rs = 0, m_rv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_serial_port uut (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .fsx(fsx),
    .tx_sample(tx_sample), .mic_mute(mic_mute), .dout(dout), .dout_en(dout_en),
    .fsr(fsr), .din(din), .rx_sample(rx_sample), .rx_vol(rx_vol), .rx_valid(rx_valid)
  );

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // One clock: update the reference with the inputs applied since the last step, then compare.
  task automatic step();
    logic exp_en, exp_bit;
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (!rst_n) begin
      m_tidx = -1; m_fsx_prev = 0; m_ridx = -1; m_fsr_prev = 0;
      m_valid = 0; m_rs = 0; m_rv = 0;
    end else begin
      // receive side (falling edge just passed)
      if (!pwr_n) begin
        m_ridx = -1; m_valid = 0;
      end else if (fsr && m_fsr_prev == 0) begin
        m_rword = int'(din); m_ridx = 1; m_valid = 0;
      end else if (m_ridx >= 1) begin
        m_rword = ((m_rword << 1) | int'(din)) & 16'hFFFF;
        m_ridx++;
        if (m_ridx == 16) begin
          m_valid = 1; m_rs = m_rword >> 3; m_rv = m_rword & 7; m_ridx = -1;
        end else m_valid = 0;
      end else m_valid = 0;
      m_fsr_prev = int'(fsr);
      // transmit side (rising edge just passed)
      if (!pwr_n) m_tidx = -1;
      else if (fsx && m_fsx_prev == 0) begin
        m_tword = mic_mute ? 0 : (int'(tx_sample) << 3); m_tidx = 0;
      end else if (m_tidx >= 0) m_tidx = (m_tidx == 15) ? -1 : m_tidx + 1;
      m_fsx_prev = int'(fsx);
    end
    exp_en  = (m_tidx >= 0) && pwr_n;
    exp_bit = exp_en && (((m_tword >> (15 - m_tidx)) & 1) == 1);
    chk("dout_en", 16'(dout_en), 16'(exp_en));
    chk("dout", 16'(dout), 16'(exp_bit));
    chk("rx_valid", 16'(rx_valid), 16'(m_valid));
    chk("rx_sample", 16'(rx_sample), 16'(m_rs));
    chk("rx_vol", 16'(rx_vol), 16'(m_rv));
  endtask

  task automatic frame(input string req, input logic [12:0] s, input logic m,
                       input logic [15:0] rw, input int len, input int hold,
                       input int pd_at, input logic [12:0] s_late);
    cur_req = req;
    for (int i = 0; i < len; i++) begin
      fsx = (i < hold);
      fsr = (i < hold);
      din = (i < 16) ? rw[15 - i] : i[1];
      tx_sample = (i < 3) ? s : s_late;
      mic_mute = (i == 0) ? m : ~m;
      pwr_n = !(pd_at >= 0 && i >= pd_at);
      step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, including a frame sync during reset
    cur_req = "R1";
    fsx = 1'b1; fsr = 1'b1;
    for (int i = 0; i < 4; i++) step();
    fsx = 1'b0; fsr = 1'b0;
    step();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();

    frame("R2/R3/R7/R8", 13'h1A5B, 1'b0, 16'hB2C5, 256, 1, -1, 13'h1A5B);
    frame("R4 late sample", 13'h0F0F, 1'b0, 16'h7FFF, 256, 1, -1, 13'h10F0);
    frame("R5 mute", 13'h1FFF, 1'b1, 16'h8001, 256, 1, -1, 13'h1FFF);
    frame("R6/R9 restart", 13'h1555, 1'b0, 16'hFFFF, 7, 1, -1, 13'h1555);
    frame("R6/R9 restart", 13'h0AAA, 1'b0, 16'h1234, 256, 1, -1, 13'h0AAA);
    frame("R11 held sync", 13'h1001, 1'b0, 16'hA5A5, 256, 5, -1, 13'h1001);
    frame("R10 power-down mid-word", 13'h1FFF, 1'b0, 16'hFFFF, 256, 1, 6, 13'h1FFF);
    frame("R10 sync ignored", 13'h1FFF, 1'b0, 16'hFFFF, 40, 1, 0, 13'h1FFF);
    frame("R2/R8 extremes", 13'h0001, 1'b0, 16'h0007, 256, 1, -1, 13'h0001);
    frame("R2/R8 extremes", 13'h1000, 1'b0, 16'hFFF8, 256, 1, -1, 13'h1000);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule